// File: doc/BRIEF.md
# Two-Wire Debug Port Frame Master

This block is the bit-level master for a two-wire debug link made of one clock line and one bidirectional data line. A host starts a transaction with a one-cycle request, a 2-bit opcode and an 8-bit value. The block then emits the matching frame on the pins. The four frame kinds are address write, address read, data write and data read. A separate request produces the long low clock pulse that resets the target. Each clock strobe is a low phase followed by a high phase, and the length of each phase is a parameter counted in system clock cycles.

Every frame opens with a strobe during which data is released. Two instruction bits follow, and data-register frames then carry a two-bit length field. Next comes a byte, least significant bit first. Data-register frames also have a bounded wait for the target to signal ready. A final strobe with data released closes the frame. Read frames return the received byte on `rdata`. Every transaction ends with a one-cycle `done`. A wait that exhausts its attempts ends the frame early and raises a sticky error.

Top module: `dbgw_master`

## Requirements
- R1: After reset, `busy`, `done`, `err`, `ck_oe` and `dat_oe` are 0, `ck_o` is 1 and `rdata` is 0. Whenever no frame runs, `ck_o` is 1 and `dat_oe` is 0.
- R2: `ck_oe` equals `link_en` delayed by one cycle, so the clock is already high when it becomes an output. While `link_en` is 0, `start` and `tgt_reset` are ignored: no frame begins and `busy` stays 0.
- R3: Each strobe drives `ck_o` low for PH_CYC cycles and then high for PH_CYC cycles, and the strobes of a frame follow each other with no gap. A new bit appears on `dat_o` in the cycle the clock falls. `dat_i` is sampled in the last high cycle of each strobe.
- R4: A frame starts with one strobe with `dat_oe`=0. Two driven instruction strobes follow, first bit then second bit: op 0 (address write) sends 1,1; op 1 (address read) sends 0,1; op 2 (data write) sends 1,0; op 3 (data read) sends 0,0.
- R5: For ops 2 and 3, two driven strobes carrying 0,0 follow the instruction bits, which selects a one-byte transfer.
- R6: Bytes move least significant bit first, one bit per strobe. Write frames (ops 0 and 2) drive the bits of `wdata` as captured at the accepted start. Read frames (ops 1 and 3) release data, and `rdata` holds the received byte once `done` pulses. Write frames leave `rdata` unchanged.
- R7: Ops 2 and 3 contain a wait of released strobes that repeats until `dat_i` is sampled 1, with at most WAIT_MAX attempts. The wait comes after the byte for op 2 and before the byte for op 3. Ops 0 and 1 have no wait.
- R8: If WAIT_MAX wait samples are all 0, the frame ends without a closing strobe. `done` pulses, `err` rises with it, and `err` stays 1 until the next accepted request.
- R9: Every frame that completes normally ends with one strobe with `dat_oe`=0. In the next cycle `done` is 1 for exactly one cycle and `busy` is 0.
- R10: `tgt_reset` in idle produces one strobe whose low phase lasts RST_CYC cycles and whose high phase lasts PH_CYC cycles, with data released, followed by `done`. When it arrives together with `start`, it wins and no frame is sent.
- R11: A `start` that arrives while `busy` is 1 is ignored: the running frame is not disturbed and no second frame follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| link_en | input | 1 | Enables the pin drivers and the acceptance of requests |
| start | input | 1 | One-cycle frame request |
| op | input | 2 | Frame kind: 0 address write, 1 address read, 2 data write, 3 data read |
| wdata | input | DATA_W | Address or data byte to send |
| tgt_reset | input | 1 | One-cycle request for a target reset pulse |
| busy | output | 1 | A frame or reset pulse is in progress |
| done | output | 1 | One-cycle pulse at the end of a transaction |
| err | output | 1 | Sticky wait timeout flag |
| rdata | output | DATA_W | Byte received by the last read frame |
| ck_o | output | 1 | Clock line value |
| ck_oe | output | 1 | Clock line output enable |
| dat_o | output | 1 | Data line value when driven |
| dat_oe | output | 1 | Data line output enable |
| dat_i | input | 1 | Data line as seen at the pin |

## Verification
The hardest cases to reach are the edges of the ready wait. A target that answers on exactly the last permitted attempt must still get a complete frame. A target that never answers must cut the frame short with no closing strobe and set the sticky error. The bench model builds the expected pin sequence for each frame and drives `dat_i` strobe by strobe from a chosen count of not-ready answers: 0, 3, one short of the limit, at the limit and past it. It also pulses `start` in the middle of a running frame, and raises `start` and `tgt_reset` in the same cycle, so that the ignore and priority rules are checked against the pins cycle by cycle.

// File: rtl/dbgw_pkg.sv
package dbgw_pkg;

  typedef enum logic [1:0] {
    OP_ADDR_WR = 2'd0,
    OP_ADDR_RD = 2'd1,
    OP_DATA_WR = 2'd2,
    OP_DATA_RD = 2'd3
  } dbgw_op_e;

  typedef enum logic [2:0] {
    FLD_IDLE,
    FLD_START,
    FLD_INS,
    FLD_LEN,
    FLD_DATA,
    FLD_WAIT,
    FLD_STOP,
    FLD_TRST
  } dbgw_fld_e;

  // Instruction bits per frame kind; bit 0 goes out first.
  function automatic logic [1:0] ins_code(dbgw_op_e op);
    case (op)
      OP_ADDR_WR: ins_code = 2'b11;
      OP_ADDR_RD: ins_code = 2'b10;
      OP_DATA_WR: ins_code = 2'b01;
      default:    ins_code = 2'b00;
    endcase
  endfunction

  function automatic logic op_is_write(dbgw_op_e op);
    op_is_write = (op == OP_ADDR_WR) || (op == OP_DATA_WR);
  endfunction

  function automatic logic op_is_data(dbgw_op_e op);
    op_is_data = (op == OP_DATA_WR) || (op == OP_DATA_RD);
  endfunction

endpackage

// File: rtl/dbgw_strobe_timer.sv
module dbgw_strobe_timer #(
  parameter int PH_CYC  = 4,
  parameter int RST_CYC = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  input  logic long_low,
  output logic ck_low,
  output logic fin
);

  localparam int MAXC = (RST_CYC > PH_CYC) ? RST_CYC : PH_CYC;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] PH_LD  = CW'(PH_CYC - 1);
  localparam logic [CW-1:0] RST_LD = CW'(RST_CYC - 1);

  typedef enum logic [1:0] {T_IDLE, T_LOW, T_HIGH} tph_e;

  tph_e          ph_q, ph_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_zero;

  always_comb begin
    cnt_zero = (cnt_q == '0);
    ck_low   = (ph_q == T_LOW);
    fin      = (ph_q == T_HIGH) && cnt_zero;
    ph_d     = ph_q;
    cnt_d    = cnt_q;
    case (ph_q)
      T_IDLE: begin
        if (go) begin
          ph_d  = T_LOW;
          cnt_d = long_low ? RST_LD : PH_LD;
        end
      end
      T_LOW: begin
        if (cnt_zero) begin
          ph_d  = T_HIGH;
          cnt_d = PH_LD;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      T_HIGH: begin
        if (cnt_zero) begin
          if (go) begin
            ph_d  = T_LOW;
            cnt_d = long_low ? RST_LD : PH_LD;
          end else begin
            ph_d = T_IDLE;
          end
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      default: ph_d = T_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= T_IDLE;
      cnt_q <= '0;
    end else begin
      ph_q  <= ph_d;
      cnt_q <= cnt_d;
    end
  end

  // Checker state: length of the current low phase and its kind.
  logic [CW-1:0] low_run_q;
  logic          long_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_run_q <= '0;
      long_q    <= 1'b0;
    end else begin
      low_run_q <= (ph_d == T_LOW) && (ph_q == T_LOW) ? low_run_q + 1'b1 : '0;
      if (go) long_q <= long_low;
    end
  end

  // R3: a new strobe is only requested when the timer is free
  a_r3_go_when_free: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> ((ph_q == T_IDLE) || fin));

  // R3: an ordinary low phase never reaches the reset length
  a_r3_short_low: assert property (@(posedge clk) disable iff (!rst_n)
    ((ph_q == T_LOW) && !long_q) |-> (low_run_q < CW'(PH_CYC)));

  // R10: the reset low phase is bounded by its own length
  a_r10_long_low: assert property (@(posedge clk) disable iff (!rst_n)
    ((ph_q == T_LOW) && long_q) |-> (low_run_q < CW'(RST_CYC)));

endmodule

// File: rtl/dbgw_shifter.sv
module dbgw_shifter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         tx_adv,
  input  logic         rx_cap,
  input  logic         rx_bit,
  output logic         tx_bit,
  output logic [W-1:0] rx_word
);

  logic [W-1:0] tx_q, tx_d;
  logic [W-1:0] rx_q, rx_d;

  always_comb begin
    tx_d = tx_q;
    rx_d = rx_q;
    if (load)        tx_d = load_val;
    else if (tx_adv) tx_d = {1'b0, tx_q[W-1:1]};
    if (rx_cap)      rx_d = {rx_bit, rx_q[W-1:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q <= '0;
      rx_q <= '0;
    end else begin
      tx_q <= tx_d;
      rx_q <= rx_d;
    end
  end

  assign tx_bit  = tx_q[0];
  assign rx_word = rx_q;

  // R6: a new byte is never loaded while bits are being sent
  a_r6_load_vs_shift: assert property (@(posedge clk) disable iff (!rst_n)
    !(load && tx_adv));

  // R6: read capture and write shifting never happen together
  a_r6_dir_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_cap && tx_adv));

endmodule

// File: rtl/dbgw_frame_ctrl.sv
module dbgw_frame_ctrl
  import dbgw_pkg::*;
#(
  parameter int W        = 8,
  parameter int WAIT_MAX = 20
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     link_on,
  input  logic     req_start,
  input  dbgw_op_e req_op,
  input  logic     req_trst,
  input  logic     fin,
  input  logic     din,
  input  logic     tx_bit,
  output logic     go,
  output logic     long_low,
  output logic     drv_en,
  output logic     drv_val,
  output logic     ld,
  output logic     tx_adv,
  output logic     rx_cap,
  output logic     busy,
  output logic     done,
  output logic     err
);

  localparam int BW = (W > 1) ? $clog2(W) : 1;
  localparam int WW = $clog2(WAIT_MAX + 1);
  localparam logic [BW-1:0] LAST_BIT  = BW'(W - 1);
  localparam logic [WW-1:0] LAST_WAIT = WW'(WAIT_MAX - 1);

  dbgw_fld_e     fld_q, fld_d;
  dbgw_op_e      op_q, op_d;
  logic [BW-1:0] idx_q, idx_d;
  logic [WW-1:0] wcnt_q, wcnt_d;
  logic          done_q, done_d;
  logic          err_q, err_d;

  logic       accept, is_wr, is_data;
  logic [1:0] ins;

  always_comb begin
    accept   = (fld_q == FLD_IDLE) && link_on && (req_start || req_trst);
    is_wr    = op_is_write(op_q);
    is_data  = op_is_data(op_q);
    ins      = ins_code(op_q);
    fld_d    = fld_q;
    op_d     = op_q;
    idx_d    = idx_q;
    wcnt_d   = wcnt_q;
    done_d   = 1'b0;
    err_d    = err_q;
    go       = 1'b0;
    long_low = 1'b0;
    ld       = 1'b0;

    if (fld_q == FLD_IDLE) begin
      if (accept) begin
        err_d = 1'b0;
        go    = 1'b1;
        idx_d = '0;
        if (req_trst) begin
          fld_d    = FLD_TRST;
          long_low = 1'b1;
        end else begin
          fld_d = FLD_START;
          op_d  = req_op;
          ld    = 1'b1;
        end
      end
    end else if (fin) begin
      case (fld_q)
        FLD_START: begin
          fld_d = FLD_INS;
          idx_d = '0;
        end
        FLD_INS: begin
          if (idx_q == BW'(1)) begin
            fld_d = is_data ? FLD_LEN : FLD_DATA;
            idx_d = '0;
          end else begin
            idx_d = idx_q + 1'b1;
          end
        end
        FLD_LEN: begin
          if (idx_q == BW'(1)) begin
            fld_d  = is_wr ? FLD_DATA : FLD_WAIT;
            idx_d  = '0;
            wcnt_d = '0;
          end else begin
            idx_d = idx_q + 1'b1;
          end
        end
        FLD_DATA: begin
          if (idx_q == LAST_BIT) begin
            fld_d  = (is_data && is_wr) ? FLD_WAIT : FLD_STOP;
            wcnt_d = '0;
          end else begin
            idx_d = idx_q + 1'b1;
          end
        end
        FLD_WAIT: begin
          if (din) begin
            fld_d = is_wr ? FLD_STOP : FLD_DATA;
            idx_d = '0;
          end else if (wcnt_q == LAST_WAIT) begin
            fld_d  = FLD_IDLE;
            err_d  = 1'b1;
            done_d = 1'b1;
          end else begin
            wcnt_d = wcnt_q + 1'b1;
          end
        end
        default: begin
          fld_d  = FLD_IDLE;
          done_d = 1'b1;
        end
      endcase
      go = (fld_d != FLD_IDLE);
    end
  end

  always_comb begin
    drv_en  = 1'b0;
    drv_val = 1'b0;
    case (fld_q)
      FLD_INS: begin
        drv_en  = 1'b1;
        drv_val = ins[idx_q[0]];
      end
      FLD_LEN: drv_en = 1'b1;
      FLD_DATA: begin
        drv_en  = is_wr;
        drv_val = is_wr & tx_bit;
      end
      default: ;
    endcase
    tx_adv = fin && (fld_q == FLD_DATA) && is_wr;
    rx_cap = fin && (fld_q == FLD_DATA) && !is_wr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fld_q  <= FLD_IDLE;
      op_q   <= OP_ADDR_WR;
      idx_q  <= '0;
      wcnt_q <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      fld_q  <= fld_d;
      op_q   <= op_d;
      idx_q  <= idx_d;
      wcnt_q <= wcnt_d;
      done_q <= done_d;
      err_q  <= err_d;
    end
  end

  assign busy = (fld_q != FLD_IDLE);
  assign done = done_q;
  assign err  = err_q;

  // R9: completion is a single-cycle pulse
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // R9: completion is only reported once the controller is idle
  a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (fld_q == FLD_IDLE));

  // R4: the opening strobe leaves the data line released
  a_r4_start_released: assert property (@(posedge clk) disable iff (!rst_n)
    (fld_q == FLD_START) |-> !drv_en);

  // R7: the ready wait never runs past its limit
  a_r7_wait_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (fld_q == FLD_WAIT) |-> (wcnt_q < WW'(WAIT_MAX)));

  // R8: the timeout flag holds until a request is accepted
  a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q && !accept) |=> err_q);

  // R11: the frame kind cannot change while a frame runs
  a_r11_op_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (fld_q != FLD_IDLE) |=> $stable(op_q));

endmodule

// File: rtl/dbgw_master.sv
module dbgw_master
  import dbgw_pkg::*;
#(
  parameter int PH_CYC   = 4,
  parameter int RST_CYC  = 100,
  parameter int WAIT_MAX = 20,
  parameter int DATA_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              link_en,
  input  logic              start,
  input  logic [1:0]        op,
  input  logic [DATA_W-1:0] wdata,
  input  logic              tgt_reset,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [DATA_W-1:0] rdata,
  output logic              ck_o,
  output logic              ck_oe,
  output logic              dat_o,
  output logic              dat_oe,
  input  logic              dat_i
);

  logic link_q;
  logic go, long_low, ck_low, fin;
  logic drv_en, drv_val, ld, tx_adv, rx_cap, tx_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) link_q <= 1'b0;
    else        link_q <= link_en;
  end

  dbgw_strobe_timer #(
    .PH_CYC  (PH_CYC),
    .RST_CYC (RST_CYC)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .go       (go),
    .long_low (long_low),
    .ck_low   (ck_low),
    .fin      (fin)
  );

  dbgw_frame_ctrl #(
    .W        (DATA_W),
    .WAIT_MAX (WAIT_MAX)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .link_on   (link_en),
    .req_start (start),
    .req_op    (dbgw_op_e'(op)),
    .req_trst  (tgt_reset),
    .fin       (fin),
    .din       (dat_i),
    .tx_bit    (tx_bit),
    .go        (go),
    .long_low  (long_low),
    .drv_en    (drv_en),
    .drv_val   (drv_val),
    .ld        (ld),
    .tx_adv    (tx_adv),
    .rx_cap    (rx_cap),
    .busy      (busy),
    .done      (done),
    .err       (err)
  );

  dbgw_shifter #(
    .W (DATA_W)
  ) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (ld),
    .load_val (wdata),
    .tx_adv   (tx_adv),
    .rx_cap   (rx_cap),
    .rx_bit   (dat_i),
    .tx_bit   (tx_bit),
    .rx_word  (rdata)
  );

  assign ck_o   = ~ck_low;
  assign ck_oe  = link_q;
  assign dat_oe = link_q & drv_en;
  assign dat_o  = drv_en & drv_val;

  // R1: with no frame running, data is released
  a_r1_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !dat_oe);

  // R1: with no frame running, the clock rests high
  a_r1_ck_high_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> ck_o);

  // R2: the clock line is high in the cycle its driver turns on
  a_r2_ck_high_on_enable: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ck_oe) |-> ck_o);

endmodule

// File: tb/dbgw_master_bench.sv
module dbgw_master_bench;

  localparam int CLK_PERIOD = 10;
  localparam int PH         = 4;
  localparam int RST        = 100;
  localparam int WMAX       = 20;

  logic       clk, rst_n, link_en, start, tgt_reset, dat_i;
  logic [1:0] op;
  logic [7:0] wdata, rdata;
  logic       busy, done, err, ck_o, ck_oe, dat_o, dat_oe;

  dbgw_master #(
    .PH_CYC(PH), .RST_CYC(RST), .WAIT_MAX(WMAX), .DATA_W(8)
  ) u_dbgw_master (
    .clk(clk), .rst_n(rst_n), .link_en(link_en), .start(start), .op(op),
    .wdata(wdata), .tgt_reset(tgt_reset), .busy(busy), .done(done),
    .err(err), .rdata(rdata), .ck_o(ck_o), .ck_oe(ck_oe), .dat_o(dat_o),
    .dat_oe(dat_oe), .dat_i(dat_i)
  );

  typedef struct {
    bit    ck;
    bit    oe;
    bit    d;
    bit    din;
    bit    bsy;
    bit    dn;
    bit    er;
    string tag;
  } ent_t;

  ent_t       q[$];
  int         checks, fails;
  bit         err_hold, link_exp, finished;
  logic [7:0] rdata_exp;

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic void note(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endfunction

  function automatic void push_strobe(bit oe, bit d, bit din, int low, string tag);
    ent_t e;
    for (int i = 0; i < low; i++) begin
      e = '{1'b0, oe, d, din, 1'b1, 1'b0, 1'b0, tag};
      q.push_back(e);
    end
    for (int i = 0; i < PH; i++) begin
      e = '{1'b1, oe, d, din, 1'b1, 1'b0, 1'b0, tag};
      q.push_back(e);
    end
  endfunction

  function automatic void push_done(bit er, string tag);
    ent_t e;
    e = '{1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, er, tag};
    q.push_back(e);
  endfunction

  // One clock cycle of the reference model: compare the pins, drive the target answer.
  task automatic cyc();
    ent_t e;
    bit   ok;
    link_exp = link_en;
    @(negedge clk);
    if (q.size() > 0) e = q.pop_front();
    else e = '{1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, err_hold, "R1"};
    if (e.dn) err_hold = e.er;
    ok = (ck_o == e.ck) && (dat_oe == e.oe) && (!e.oe || dat_o == e.d) &&
         (busy == e.bsy) && (done == e.dn) && (err == e.er);
    note(ok, e.tag, "pins{ck,oe,d,busy,done,err}",
         int'({ck_o, dat_oe, dat_o, busy, done, err}),
         int'({e.ck, e.oe, e.oe ? e.d : dat_o, e.bsy, e.dn, e.er}));
    note(ck_oe == link_exp, "R2", "ck_oe", int'(ck_oe), int'(link_exp));
    dat_i = e.din;
  endtask

  task automatic drain();
    while (q.size() > 0) cyc();
    cyc();
  endtask

  // Expected frame: nwait = number of not-ready answers before ready.
  task automatic frame(bit [1:0] o, logic [7:0] w, logic [7:0] rb, int nwait, bit poke);
    bit [1:0] ins;
    bit       is_rd, tmo;
    case (o)
      2'd0:    ins = 2'b11;
      2'd1:    ins = 2'b10;
      2'd2:    ins = 2'b01;
      default: ins = 2'b00;
    endcase
    is_rd = o[0];
    tmo   = 1'b0;
    cyc();
    op = o; wdata = w; start = 1'b1;
    push_strobe(1'b0, 1'b0, 1'b0, PH, "R3");
    push_strobe(1'b1, ins[0], 1'b0, PH, "R4");
    push_strobe(1'b1, ins[1], 1'b0, PH, "R4");
    if (o[1]) begin
      push_strobe(1'b1, 1'b0, 1'b0, PH, "R5");
      push_strobe(1'b1, 1'b0, 1'b0, PH, "R5");
    end
    if (!is_rd) begin
      for (int i = 0; i < 8; i++) push_strobe(1'b1, w[i], 1'b0, PH, "R6");
    end
    if (o[1]) begin
      for (int k = 0; k < nwait && k < WMAX; k++) push_strobe(1'b0, 1'b0, 1'b0, PH, "R7");
      if (nwait >= WMAX) tmo = 1'b1;
      else push_strobe(1'b0, 1'b0, 1'b1, PH, "R7");
    end
    if (!tmo && is_rd) begin
      for (int i = 0; i < 8; i++) push_strobe(1'b0, 1'b0, rb[i], PH, "R6");
    end
    if (tmo) push_done(1'b1, "R8");
    else begin
      push_strobe(1'b0, 1'b0, 1'b0, PH, "R9");
      push_done(1'b0, "R9");
    end
    cyc();
    start = 1'b0;
    if (poke) begin
      // R11: a start in the middle of the frame, with other op and data
      repeat (6) cyc();
      op = ~o; wdata = ~w; start = 1'b1;
      cyc();
      start = 1'b0;
    end
    drain();
    if (is_rd && !tmo) rdata_exp = rb;
    note(rdata == rdata_exp, "R6", "rdata", int'(rdata), int'(rdata_exp));
    note(err == tmo, "R8", "err after frame", int'(err), int'(tmo));
    if (poke) note(busy == 1'b0 && done == 1'b0, "R11", "no extra frame", int'(busy), 0);
  endtask

  task automatic trst_req(bit with_start);
    cyc();
    tgt_reset = 1'b1; start = with_start; op = 2'd0;
    push_strobe(1'b0, 1'b0, 1'b0, RST, "R10");
    push_done(1'b0, "R10");
    cyc();
    tgt_reset = 1'b0; start = 1'b0;
    drain();
    note(err == 1'b0, "R10", "err cleared by reset request", int'(err), 0);
  endtask

  initial begin
    checks = 0; fails = 0; err_hold = 1'b0; finished = 1'b0; rdata_exp = 8'h00;
    rst_n = 1'b0; link_en = 1'b0; start = 1'b0; tgt_reset = 1'b0;
    op = 2'd0; wdata = 8'h00; dat_i = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    note(busy == 0 && done == 0 && err == 0 && ck_o == 1 && ck_oe == 0 && dat_oe == 0 &&
         rdata == 8'h00, "R1", "reset state",
         int'({busy, done, err, ck_o, ck_oe, dat_oe}), int'(6'b000100));

    // R2: requests with the link off are ignored
    cyc();
    start = 1'b1; tgt_reset = 1'b1; op = 2'd3;
    cyc();
    start = 1'b0; tgt_reset = 1'b0;
    repeat (4) cyc();
    note(busy == 1'b0, "R2", "busy with link off", int'(busy), 0);
    link_en = 1'b1;
    repeat (3) cyc();

    frame(2'd0, 8'hB4, 8'h00, 0, 1'b0);   // address write
    frame(2'd1, 8'h00, 8'h5A, 0, 1'b0);   // address read
    frame(2'd2, 8'h3C, 8'h00, 3, 1'b1);   // data write, short wait, start while busy
    frame(2'd3, 8'h00, 8'hC3, 0, 1'b0);   // data read, ready at once
    frame(2'd2, 8'h81, 8'h00, 25, 1'b0);  // data write that times out
    frame(2'd3, 8'h00, 8'h96, 19, 1'b0);  // ready on the last permitted attempt
    frame(2'd0, 8'h01, 8'h00, 0, 1'b0);   // write leaves rdata alone
    frame(2'd3, 8'h00, 8'h11, 20, 1'b0);  // read times out, rdata kept
    trst_req(1'b1);                       // reset wins over a simultaneous start
    frame(2'd1, 8'h00, 8'hE7, 0, 1'b0);
    trst_req(1'b0);

    // R2: turning the link off releases the clock driver
    cyc();
    link_en = 1'b0;
    repeat (3) cyc();

    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule